// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a small synchronous burst SRAM that has a read pipeline. Each lane of the data word holds a data byte and a parity bit. The model registers every control and address input on the rising clock edge. The one exception is the output-enable input, which acts asynchronously on the output-drive flag.

A burst can start from either of two address strobes, and each strobe has its own priority and chip-select gating. Once a burst has started, a step input either advances a 2-bit burst counter or holds it. A static order input chooses between linear (wrapping) and interleaved (XOR) address sequencing. Writes are decoded from three controls: a write-all input, a byte-write enable and per-lane write strobes.

Read data for a command sampled on one edge appears after the following edge. A deselect cycle turns the output-drive flag off one edge later. The flag stands in for a tristate data bus. A sleep input comes from a separate low-power controller and turns any cycle into a no-operation.

Top module: `pburst_sram`

## Requirements
- R1: After reset no burst is open and `drive_o` is low. Cycles with both strobes high do nothing until a burst is started.
- R2: A read taken on edge N puts the addressed word on `rdata_o` after edge N+1, with `drive_o` high while `out_en_n_i` is low.
- R3: A low `start_p_n_i` is ignored while `ce_n_i` is high, and `start_c_n_i` then decides the cycle. A strobe that is honoured while the device is not selected is a deselect. Selected means `ce_n_i`=0, `ce_hi_i`=1 and `ce2_n_i`=0.
- R4: After a deselect on edge N, `drive_o` is low after edge N+1. Continue cycles stay idle until a new burst starts.
- R5: A burst started by `start_p_n_i` always reads on its first edge. A write on the next edge (continue cycle) stores to the burst address.
- R6: A burst started by `start_c_n_i` (with the other strobe not honoured) is a write if any lane write is decoded, and a read otherwise.
- R7: On a continue cycle, `step_n_i`=0 advances the burst count before the access and `step_n_i`=1 repeats the current address. This also holds while `ce_n_i` is high.
- R8: With `order_il_i`=0, burst k uses low address bits (A+k) mod 4. The upper address bits are unchanged.
- R9: With `order_il_i`=1, burst k uses low address bits A XOR k.
- R10: Write decode works as follows. `wr_all_n_i`=0 writes all lanes. Otherwise `wr_byte_en_n_i`=0 writes every lane whose `lane_wr_n_i` bit is 0. Lane i is `wdata_i[i*9 +: 9]`, and its bit 8 is the parity bit, which is written together with the byte. When no lane is selected the cycle is a read.
- R11: `out_en_n_i`=1 forces `drive_o` low in the same cycle without disturbing the pipeline.
- R12: After a write on edge N, `drive_o` is low after edge N+1.
- R13: With `sleep_i`=1 an edge stores nothing and leaves the burst state unchanged, and `drive_o` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address; the two LSBs seed the burst |
| ce_n_i | input | 1 | Primary chip select, active low |
| ce_hi_i | input | 1 | Secondary chip select, active high |
| ce2_n_i | input | 1 | Secondary chip select, active low |
| start_p_n_i | input | 1 | Burst strobe gated by the primary select, active low |
| start_c_n_i | input | 1 | Burst strobe with read/write decode, active low |
| step_n_i | input | 1 | Burst advance (0) or suspend (1) |
| wr_all_n_i | input | 1 | Write all lanes, active low |
| wr_byte_en_n_i | input | 1 | Enables the per-lane write strobes, active low |
| lane_wr_n_i | input | LANES | Per-lane write strobes, active low |
| order_il_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Gate from the low-power controller |
| wdata_i | input | LANES*9 | Write data, 8 data bits plus parity per lane |
| rdata_o | output | LANES*9 | Registered read data |
| drive_o | output | 1 | Output-drive flag (tristate stand-in) |

## Verification
All 64 words are filled through single-cycle write bursts. Burst reads are then swept over every start offset, for several upper-address values, in both burst orders. This separates wrapping addition from XOR sequencing and shows that the upper bits never change. A suspend within each burst separates advancing from holding. Lane-strobe patterns 00 through 11 separate partial writes from full writes, and show that an empty lane set becomes a read. Strobe and select combinations separate an ignored strobe, which continues the burst, from a deselect, which silences the output. Sleep and output-enable pulses show that the pipeline state survives both.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
    localparam int PBS_CNT_W = 2;
    localparam int PBS_PAR_W = 1;

    typedef enum logic [1:0] {
        PBS_NOP = 2'd0,
        PBS_RD  = 2'd1,
        PBS_WR  = 2'd2
    } pbs_op_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_DESEL = 2'd2,
        EV_CONT  = 2'd3
    } pbs_evt_e;

    typedef struct packed {
        logic sel;
        logic p_seen;
        logic c_seen;
    } pbs_strobe_t;

    // Low burst address bits from the seed and the count
    function automatic logic [PBS_CNT_W-1:0] pbs_order(
        input logic [PBS_CNT_W-1:0] seed,
        input logic [PBS_CNT_W-1:0] cnt,
        input logic                 il
    );
        return il ? (seed ^ cnt) : (seed + cnt);
    endfunction
endpackage

// File: rtl/pbs_wdec.sv
`timescale 1ns/1ps
module pbs_wdec #(
    parameter int LANES = 2
) (
    input  logic             wr_all_n_i,
    input  logic             wr_byte_en_n_i,
    input  logic [LANES-1:0] lane_wr_n_i,
    output logic [LANES-1:0] lane_we_o,
    output logic             wr_any_o
);
    always_comb begin
        if (!wr_all_n_i)
            lane_we_o = '1;
        else if (!wr_byte_en_n_i)
            lane_we_o = ~lane_wr_n_i;
        else
            lane_we_o = '0;
        wr_any_o = |lane_we_o;
    end
endmodule

// File: rtl/pbs_ctrl.sv
`timescale 1ns/1ps
module pbs_ctrl import pbs_pkg::*; #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ce_n_i,
    input  logic          ce_hi_i,
    input  logic          ce2_n_i,
    input  logic          start_p_n_i,
    input  logic          start_c_n_i,
    input  logic          step_n_i,
    input  logic          order_il_i,
    input  logic          wr_any_i,
    output pbs_op_e       op_o,
    output logic [AW-1:0] op_addr_o
);
    pbs_strobe_t          stb;
    pbs_evt_e             evt;
    logic                 active_q;
    logic [AW-1:0]        base_q;
    logic [PBS_CNT_W-1:0] cnt_q;
    logic [PBS_CNT_W-1:0] cnt_nx;

    always_comb begin
        stb.sel    = !ce_n_i && ce_hi_i && !ce2_n_i;
        stb.p_seen = !start_p_n_i && !ce_n_i;
        stb.c_seen = !start_c_n_i && !stb.p_seen;

        evt = EV_NONE;
        if (!sleep_i) begin
            if (stb.p_seen || stb.c_seen)
                evt = stb.sel ? EV_START : EV_DESEL;
            else if (active_q)
                evt = EV_CONT;
        end

        cnt_nx    = step_n_i ? cnt_q : cnt_q + 1'b1;
        op_o      = PBS_NOP;
        op_addr_o = addr_i;
        case (evt)
            EV_START: op_o = (stb.p_seen || !wr_any_i) ? PBS_RD : PBS_WR;
            EV_CONT: begin
                op_o      = wr_any_i ? PBS_WR : PBS_RD;
                op_addr_o = {base_q[AW-1:PBS_CNT_W],
                             pbs_order(base_q[PBS_CNT_W-1:0], cnt_nx, order_il_i)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            case (evt)
                EV_START: begin
                    active_q <= 1'b1;
                    base_q   <= addr_i;
                    cnt_q    <= '0;
                end
                EV_DESEL: active_q <= 1'b0;
                EV_CONT:  cnt_q    <= cnt_nx;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pbs_array.sv
`timescale 1ns/1ps
module pbs_array import pbs_pkg::*; #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pbs_op_e                 op_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [LANES-1:0]        lane_we_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rd_valid_o
);
    localparam int DEPTH = 1 << AW;

    logic          rd1_q;
    logic [AW-1:0] a1_q;
    logic          rd2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd1_q <= 1'b0;
            rd2_q <= 1'b0;
            a1_q  <= '0;
        end else begin
            rd1_q <= (op_i == PBS_RD);
            a1_q  <= addr_i;
            rd2_q <= rd1_q;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            logic [LANE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (op_i == PBS_WR && lane_we_i[g])
                    mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
                if (rd1_q)
                    q <= mem[a1_q];
            end
            assign rdata_o[g*LANE_W +: LANE_W] = q;
        end
    endgenerate

    assign rd_valid_o = rd2_q;
endmodule

// File: rtl/pburst_sram.sv
`timescale 1ns/1ps
module pburst_sram import pbs_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [ADDR_W-1:0]                     addr_i,
    input  logic                                  ce_n_i,
    input  logic                                  ce_hi_i,
    input  logic                                  ce2_n_i,
    input  logic                                  start_p_n_i,
    input  logic                                  start_c_n_i,
    input  logic                                  step_n_i,
    input  logic                                  wr_all_n_i,
    input  logic                                  wr_byte_en_n_i,
    input  logic [LANES-1:0]                      lane_wr_n_i,
    input  logic                                  order_il_i,
    input  logic                                  out_en_n_i,
    input  logic                                  sleep_i,
    input  logic [LANES*(BYTE_W+PBS_PAR_W)-1:0]   wdata_i,
    output logic [LANES*(BYTE_W+PBS_PAR_W)-1:0]   rdata_o,
    output logic                                  drive_o
);
    localparam int LANE_W = BYTE_W + PBS_PAR_W;

    logic [LANES-1:0]  lane_we;
    logic              wr_any;
    pbs_op_e           op;
    logic [ADDR_W-1:0] op_addr;
    logic              rd_valid;

    pbs_wdec #(.LANES(LANES)) u_wdec (
        .wr_all_n_i     (wr_all_n_i),
        .wr_byte_en_n_i (wr_byte_en_n_i),
        .lane_wr_n_i    (lane_wr_n_i),
        .lane_we_o      (lane_we),
        .wr_any_o       (wr_any)
    );

    pbs_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sleep_i     (sleep_i),
        .addr_i      (addr_i),
        .ce_n_i      (ce_n_i),
        .ce_hi_i     (ce_hi_i),
        .ce2_n_i     (ce2_n_i),
        .start_p_n_i (start_p_n_i),
        .start_c_n_i (start_c_n_i),
        .step_n_i    (step_n_i),
        .order_il_i  (order_il_i),
        .wr_any_i    (wr_any),
        .op_o        (op),
        .op_addr_o   (op_addr)
    );

    pbs_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .addr_i     (op_addr),
        .wdata_i    (wdata_i),
        .lane_we_i  (lane_we),
        .rdata_o    (rdata_o),
        .rd_valid_o (rd_valid)
    );

    // output enable acts without a clock on the drive flag
    assign drive_o = rd_valid && !out_en_n_i;
endmodule

// File: rtl/pbs_checker.sv
`timescale 1ns/1ps
module pbs_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_i,
    input logic             ce_n_i,
    input logic             ce_hi_i,
    input logic             ce2_n_i,
    input logic             start_p_n_i,
    input logic             start_c_n_i,
    input logic             wr_all_n_i,
    input logic             wr_byte_en_n_i,
    input logic [LANES-1:0] lane_wr_n_i,
    input logic             out_en_n_i,
    input logic             drive_o
);
    logic sel, p_hit, c_hit, desel, wr_req;

    always_comb begin
        sel    = !ce_n_i && ce_hi_i && !ce2_n_i;
        p_hit  = !sleep_i && !start_p_n_i && !ce_n_i;
        c_hit  = !sleep_i && !p_hit && !start_c_n_i;
        desel  = (p_hit || c_hit) && !sel;
        wr_req = !wr_all_n_i || (!wr_byte_en_n_i && !(&lane_wr_n_i));
    end

    AST_DESEL_DARK: assert property (@(posedge clk) disable iff (rst)
        desel |-> ##2 !drive_o); // R4
    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> ##2 !drive_o); // R13
    AST_PSTART_READS: assert property (@(posedge clk) disable iff (rst)
        (p_hit && sel) |-> ##2 (drive_o || out_en_n_i)); // R5
    AST_CWRITE_DARK: assert property (@(posedge clk) disable iff (rst)
        (c_hit && sel && wr_req) |-> ##2 !drive_o); // R12
    AST_CREAD_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (c_hit && sel && !wr_req) |-> ##2 (drive_o || out_en_n_i)); // R6
endmodule

bind pburst_sram pbs_checker #(.LANES(LANES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sleep_i        (sleep_i),
    .ce_n_i         (ce_n_i),
    .ce_hi_i        (ce_hi_i),
    .ce2_n_i        (ce2_n_i),
    .start_p_n_i    (start_p_n_i),
    .start_c_n_i    (start_c_n_i),
    .wr_all_n_i     (wr_all_n_i),
    .wr_byte_en_n_i (wr_byte_en_n_i),
    .lane_wr_n_i    (lane_wr_n_i),
    .out_en_n_i     (out_en_n_i),
    .drive_o        (drive_o)
);

// File: tb/pburst_sram_test.sv
`timescale 1ns/1ps
module pburst_sram_test;
    localparam int AW = 6;
    localparam int LN = 2;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b0, ce_hi = 1'b1, ce2_n = 1'b0;
    logic          sp_n = 1'b1, sc_n = 1'b1, step_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [LN-1:0] lane_n = '1;
    logic          il = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference state
    logic [DW-1:0] ref_mem [1<<AW];
    bit            r_act = 1'b0;
    logic [AW-1:0] r_base = '0;
    logic [1:0]    r_cnt = '0;
    bit            p_rd = 1'b0;
    logic [DW-1:0] p_data = '0;
    bit            e_rd = 1'b0;
    logic [DW-1:0] e_data = '0;

    always #2 clk = ~clk;

    pburst_sram uut (
        .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .ce_hi_i(ce_hi),
        .ce2_n_i(ce2_n), .start_p_n_i(sp_n), .start_c_n_i(sc_n), .step_n_i(step_n),
        .wr_all_n_i(gw_n), .wr_byte_en_n_i(bwe_n), .lane_wr_n_i(lane_n),
        .order_il_i(il), .out_en_n_i(oe_n), .sleep_i(sleep), .wdata_i(wdata),
        .rdata_o(rdata), .drive_o(drive)
    );

    function automatic logic [DW-1:0] dval(input int a);
        return DW'((a * 4099 + 77) ^ (a << 11));
    endfunction

    task automatic check_out(input string tag);
        bit ed;
        ed = e_rd && !oe_n;
        checks++;
        if (drive !== ed || (ed && rdata !== e_data)) begin
            fails++;
            $display("FAIL %s: drive=%0b rdata=%h expected drive=%0b rdata=%h",
                     tag, drive, rdata, ed, e_data);
        end
    endtask

    // one clock cycle with reference update and output check
    task automatic tick(input string tag);
        bit sel, pseen;
        int op;
        logic [AW-1:0] a;
        logic [1:0] cn;
        logic [LN-1:0] m;
        bit nrd;
        logic [DW-1:0] nd;
        m = !gw_n ? '1 : (!bwe_n ? ~lane_n : '0);
        sel = !ce_n && ce_hi && !ce2_n;
        pseen = !sp_n && !ce_n;
        op = 0;
        a = addr;
        if (sleep) op = 0;
        else if (pseen || !sc_n) begin
            if (sel) begin
                r_act = 1'b1; r_base = addr; r_cnt = 2'd0;
                op = (pseen || m == '0) ? 1 : 2;
            end else r_act = 1'b0;
        end else if (r_act) begin
            cn = step_n ? r_cnt : r_cnt + 2'd1;
            r_cnt = cn;
            a = {r_base[AW-1:2], il ? (r_base[1:0] ^ cn) : (r_base[1:0] + cn)};
            op = (m != '0) ? 2 : 1;
        end
        nrd = (op == 1);
        nd = ref_mem[a];
        if (op == 2)
            for (int i = 0; i < LN; i++)
                if (m[i]) ref_mem[a][i*LW +: LW] = wdata[i*LW +: LW];
        @(posedge clk);
        #1;
        e_rd = p_rd; e_data = p_data;
        p_rd = nrd;  p_data = nd;
        check_out(tag);
    endtask

    task automatic quiet();
        sp_n = 1'b1; sc_n = 1'b1; step_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; lane_n = '1;
        ce_n = 1'b0; ce_hi = 1'b1; ce2_n = 1'b0; sleep = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        checks++;
        if (drive !== 1'b0) begin
            fails++;
            $display("FAIL R1: drive=%0b expected 0 after reset", drive);
        end
        // R1: continue cycles with no burst open
        quiet(); step_n = 1'b0;
        tick("R1"); tick("R1"); tick("R1");

        // R6: fill every word with single write bursts started by start_c
        for (int a = 0; a < (1 << AW); a++) begin
            quiet(); sc_n = 1'b0; gw_n = 1'b0;
            addr = AW'(a); wdata = dval(a);
            tick("R6");
        end
        quiet(); tick("R12"); tick("R12");

        // R8/R9/R7/R2: burst read sweeps
        for (int mo = 0; mo < 2; mo++) begin
            il = mo[0];
            for (int hi = 0; hi < 16; hi += 5) begin
                for (int b = 0; b < 4; b++) begin
                    quiet(); sp_n = 1'b0; addr = AW'(hi * 4 + b);
                    tick("R5");
                    quiet(); step_n = 1'b0;
                    tick(mo ? "R9" : "R8");
                    step_n = 1'b1;
                    tick("R7");
                    step_n = 1'b0;
                    tick(mo ? "R9" : "R8");
                    tick(mo ? "R9" : "R8");
                    tick("R2");
                end
            end
        end
        il = 1'b0;

        // R10: lane strobe patterns, then read back
        for (int lm = 0; lm < 4; lm++) begin
            quiet(); sc_n = 1'b0; bwe_n = 1'b0; lane_n = LN'(lm);
            addr = AW'(40 + lm); wdata = ~dval(lm + 100);
            tick("R10");
            quiet(); sp_n = 1'b0; addr = AW'(40 + lm);
            tick("R10");
            quiet(); tick("R10"); tick("R10");
        end
        // R10: write-all overrides the lane strobes
        quiet(); sc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; lane_n = '1;
        addr = AW'(44); wdata = dval(999);
        tick("R10");
        quiet(); sp_n = 1'b0; addr = AW'(44); tick("R10");
        quiet(); tick("R10"); tick("R10");

        // R6: start_c with no write decoded reads
        quiet(); sc_n = 1'b0; addr = AW'(12); tick("R6");
        quiet(); tick("R6"); tick("R6");

        // R5: start_p reads, next edge writes at the burst address
        quiet(); sp_n = 1'b0; gw_n = 1'b0; addr = AW'(20); wdata = dval(555);
        tick("R5");
        quiet(); gw_n = 1'b0; wdata = dval(556);
        tick("R5");
        quiet(); tick("R5"); tick("R5"); tick("R5");

        // R3: start_p ignored with primary select high -> burst continues
        quiet(); sp_n = 1'b0; addr = AW'(8); tick("R3");
        quiet(); ce_n = 1'b1; sp_n = 1'b0; step_n = 1'b0; tick("R3");
        quiet(); ce_n = 1'b1; step_n = 1'b0; tick("R7");
        // R3/R4: start_c with primary select high deselects
        quiet(); ce_n = 1'b1; sp_n = 1'b0; sc_n = 1'b0; tick("R3");
        quiet(); step_n = 1'b0; tick("R4"); tick("R4"); tick("R4");
        // secondary selects inactive
        quiet(); sp_n = 1'b0; addr = AW'(9); tick("R3");
        quiet(); ce_hi = 1'b0; sp_n = 1'b0; tick("R3");
        quiet(); tick("R4"); tick("R4");
        quiet(); sp_n = 1'b0; addr = AW'(10); tick("R3");
        quiet(); ce2_n = 1'b1; sc_n = 1'b0; tick("R3");
        quiet(); step_n = 1'b0; tick("R4"); tick("R4");

        // R11: output enable acts between edges
        quiet(); sp_n = 1'b0; addr = AW'(33); tick("R11");
        quiet(); tick("R11"); tick("R11");
        oe_n = 1'b1; #0.5;
        checks++;
        if (drive !== 1'b0) begin
            fails++; $display("FAIL R11: drive=%0b expected 0 with oe high", drive);
        end
        oe_n = 1'b0; #0.5;
        check_out("R11");
        oe_n = 1'b1; tick("R11"); oe_n = 1'b0; tick("R11");

        // R13: sleep blocks a write and holds the burst
        quiet(); sp_n = 1'b0; addr = AW'(30); tick("R13");
        quiet(); sleep = 1'b1; sc_n = 1'b0; gw_n = 1'b0;
        addr = AW'(31); wdata = dval(777); tick("R13");
        quiet(); tick("R13"); tick("R13");
        quiet(); sp_n = 1'b0; addr = AW'(31); tick("R13");
        quiet(); tick("R13"); tick("R13");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule